// File: doc/BRIEF.md
# Four-Address I2C Target Bank

This block lets one piece of logic answer on an I2C bus as four separate targets. It watches the bus lines on a fast system clock and finds START and STOP conditions and SCL edges in that clock domain. It takes in the address byte, most significant bit first. The byte is accepted when its upper five address bits equal the fixed prefix `10101`. The two low address bits then select one of four targets, indexed 0 to 3. An accepted address is acknowledged. A rejected one is left unanswered, and the block stays silent until the next START.

Each target owns one 8-bit register. After reset, target XY holds `110011XY`. A write transfers one byte from the controller into the selected register and acknowledges it. A read shifts the selected register out on SDA, most significant bit first. Both bus lines leave the block only as open-drain pull-low enables, so the surrounding pad logic forms the wired-AND. A configuration input can hold SCL low for a set number of system clocks after the address acknowledge, which stretches the clock before the data byte. Each transaction carries a single data byte.

Top module: `i2c_quad_target`

## Requirements
- R1: After reset, `sda_oe` and `scl_oe` are 0, `wr_strobe` is 0, and the 8-bit slice `tgt_data[8*i+7:8*i]` of target i holds `110011` followed by the two-bit index i (0xCC, 0xCD, 0xCE, 0xCF).
- R2: An address byte whose seven address bits are `10101XY` is acknowledged: SDA is low while SCL is high during the 9th clock.
- R3: An address whose upper five bits differ from `10101` gets no acknowledge. The block then drives neither line until the next START, and no register changes.
- R4: With the R/W bit (the 8th bit of the address byte) at 0, the next 8 bits are stored, MSB first, into target XY's slice of `tgt_data` and acknowledged. `wr_strobe[XY]` pulses for exactly one system clock, and no other strobe bit rises.
- R5: With the R/W bit at 1, target XY's register is driven on SDA, MSB first, across the next 8 clocks. `sda_oe` changes only while SCL is low.
- R6: A read after a write returns the value written, and a write leaves the other three targets' registers unchanged.
- R7: With `stretch_cycles` = N > 0, `scl_oe` is high for exactly N system clocks once per addressed transaction, after the address acknowledge and before the data byte. With N = 0, `scl_oe` never rises.
- R8: A START (SDA falling while SCL is high) or a STOP (SDA rising while SCL is high) in the middle of a byte abandons it. The partial byte is not stored, and the next byte after a START is treated as an address.
- R9: After the 8th read bit the block releases SDA for the controller's acknowledge bit. It drives nothing more until the next START, whether the controller acknowledged or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the SCL wire |
| sda_i | input | 1 | Sensed level of the SDA wire |
| stretch_cycles | input | STRETCH_W (8) | Clock-stretch length in system clocks, 0 disables stretching |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| tgt_data | output | N_TGT*8 (32) | Current register of each target, target i in bits 8i+7..8i |
| wr_strobe | output | N_TGT (4) | One-clock pulse on the bit of the target that just stored a byte |

## Verification
The assertions assume a well-behaved controller. Each SCL low and high phase lasts several system clocks longer than the synchroniser delay. The controller moves SDA only while SCL is low, except to make a START or a STOP. It waits for SCL to actually rise before timing its high phase, and it never changes `stretch_cycles` during a transaction. The bench keeps to these assumptions by construction: one behavioural controller task waits six system clocks around every line change and polls the wired SCL before it counts the high phase. The stretch setting is changed only between a STOP and the next START.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK_WAIT,
      ST_AACK,
      ST_HOLD,
      ST_WDATA,
      ST_WACK_WAIT,
      ST_WACK,
      ST_RDATA,
      ST_RACK,
      ST_SKIP
   } tgt_state_t;

   localparam int LINE_SCL = 0;
   localparam int LINE_SDA = 1;
   localparam int ADDR_BITS = 7;
endpackage

// File: rtl/i2cq_line_sync.sv
module i2cq_line_sync #(
   parameter int STAGES = 2,
   parameter int LINES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] din,
   output logic [LINES-1:0] level,
   output logic [LINES-1:0] rise,
   output logic [LINES-1:0] fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cq_line_sync: STAGES must be at least 2");
      end
      if (LINES < 1) begin : g_bad_lines
         $error("i2cq_line_sync: LINES must be at least 1");
      end
   endgenerate

   logic [LINES-1:0] prev;

   generate
      for (genvar l = 0; l < LINES; l++) begin : g_line
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], din[l]};
         end
         assign level[l] = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= level;
   end

   assign rise = level & ~prev;
   assign fall = ~level & prev;
endmodule

// File: rtl/i2cq_stretch_timer.sv
module i2cq_stretch_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] len,
   output logic         hold,
   output logic         done
);
   generate
      if (W < 1) begin : g_bad_w
         $error("i2cq_stretch_timer: W must be positive");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         hold <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            if (len == '0) begin
               done <= 1'b1;
            end else begin
               cnt  <= len;
               hold <= 1'b1;
            end
         end else if (hold) begin
            if (cnt == W'(1)) begin
               hold <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt <= cnt - W'(1);
            end
         end
      end
   end

   assert_done_ends_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hold) && !hold && !$past(load)) |-> done);
endmodule

// File: rtl/i2cq_reg_bank.sv
module i2cq_reg_bank #(
   parameter int N_TGT     = 4,
   parameter int DW        = 8,
   parameter int PRESET_HI = 'b110011
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [$clog2(N_TGT)-1:0] wr_sel,
   input  logic [DW-1:0]         wr_data,
   input  logic [$clog2(N_TGT)-1:0] rd_sel,
   output logic [DW-1:0]         rd_data,
   output logic [N_TGT*DW-1:0]   regs_flat,
   output logic [N_TGT-1:0]      wr_strobe
);
   localparam int IDX_W = $clog2(N_TGT);
   localparam int HI_W  = DW - IDX_W;

   generate
      if (HI_W < 1) begin : g_bad_dw
         $error("i2cq_reg_bank: DW must exceed the index width");
      end
      if (N_TGT != (1 << IDX_W)) begin : g_bad_n
         $error("i2cq_reg_bank: N_TGT must be a power of two");
      end
   endgenerate

   logic [DW-1:0] regs [N_TGT];

   generate
      for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
         localparam logic [DW-1:0] RST_VAL = {HI_W'(PRESET_HI), IDX_W'(t)};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs[t]      <= RST_VAL;
               wr_strobe[t] <= 1'b0;
            end else begin
               wr_strobe[t] <= wr_en && (wr_sel == IDX_W'(t));
               if (wr_en && (wr_sel == IDX_W'(t))) regs[t] <= wr_data;
            end
         end
         assign regs_flat[t*DW +: DW] = regs[t];
      end
   endgenerate

   assign rd_data = regs[rd_sel];

   assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_strobe));
   assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (regs[$past(wr_sel)] == $past(wr_data)));
   assert_idle_regs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_flat));
endmodule

// File: rtl/i2c_quad_target.sv
module i2c_quad_target
   import i2cq_pkg::*;
#(
   parameter int N_TGT       = 4,
   parameter int DW          = 8,
   parameter int ADDR_PREFIX = 'b10101,
   parameter int PRESET_HI   = 'b110011,
   parameter int STRETCH_W   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   input  logic [STRETCH_W-1:0] stretch_cycles,
   output logic                 scl_oe,
   output logic                 sda_oe,
   output logic [N_TGT*DW-1:0]  tgt_data,
   output logic [N_TGT-1:0]     wr_strobe
);
   localparam int IDX_W = $clog2(N_TGT);
   localparam int PFX_W = ADDR_BITS - IDX_W;
   localparam int BIT_W = $clog2(DW + 1);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("i2c_quad_target: the bus carries 8-bit bytes");
      end
      if (PFX_W < 1) begin : g_bad_pfx
         $error("i2c_quad_target: too many targets for a 7-bit address");
      end
   endgenerate

   logic [1:0] lvl, rse, fal;
   logic       scl_s, sda_s, scl_r, scl_f, start_ev, stop_ev;

   i2cq_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .din({sda_i, scl_i}),
      .level(lvl), .rise(rse), .fall(fal));

   assign scl_s    = lvl[LINE_SCL];
   assign sda_s    = lvl[LINE_SDA];
   assign scl_r    = rse[LINE_SCL];
   assign scl_f    = fal[LINE_SCL];
   assign start_ev = fal[LINE_SDA] & scl_s;
   assign stop_ev  = rse[LINE_SDA] & scl_s;

   tgt_state_t        state;
   logic [DW-2:0]     shreg;
   logic [BIT_W-1:0]  bitcnt;
   logic [IDX_W-1:0]  sel;
   logic              is_rd;
   logic [DW-1:0]     txbyte;
   logic [DW-1:0]     rd_data;
   logic [DW-1:0]     in_byte;
   logic              hold_go, hold_done, wr_go, bus_evt;

   assign in_byte = {shreg, sda_s};
   assign bus_evt = start_ev | stop_ev;
   assign hold_go = (state == ST_AACK) && scl_f && !bus_evt;
   assign wr_go   = (state == ST_WDATA) && scl_r && (bitcnt == BIT_W'(DW-1)) && !bus_evt;

   i2cq_stretch_timer #(.W(STRETCH_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(hold_go), .len(stretch_cycles),
      .hold(scl_oe), .done(hold_done));

   i2cq_reg_bank #(.N_TGT(N_TGT), .DW(DW), .PRESET_HI(PRESET_HI)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_go), .wr_sel(sel), .wr_data(in_byte),
      .rd_sel(sel), .rd_data(rd_data), .regs_flat(tgt_data), .wr_strobe(wr_strobe));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         shreg  <= '0;
         bitcnt <= '0;
         sel    <= '0;
         is_rd  <= 1'b0;
         txbyte <= '0;
         sda_oe <= 1'b0;
      end else if (start_ev) begin
         state  <= ST_ADDR;
         bitcnt <= '0;
         sda_oe <= 1'b0;
      end else if (stop_ev) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR: if (scl_r) begin
               shreg  <= in_byte[DW-2:0];
               bitcnt <= bitcnt + BIT_W'(1);
               if (bitcnt == BIT_W'(DW-1)) begin
                  if (in_byte[DW-1:IDX_W+1] == PFX_W'(ADDR_PREFIX)) begin
                     sel   <= in_byte[IDX_W:1];
                     is_rd <= in_byte[0];
                     state <= ST_AACK_WAIT;
                  end else begin
                     state <= ST_SKIP;
                  end
               end
            end
            ST_AACK_WAIT: if (scl_f) begin
               sda_oe <= 1'b1;
               state  <= ST_AACK;
            end
            ST_AACK: if (scl_f) begin
               sda_oe <= is_rd ? ~rd_data[DW-1] : 1'b0;
               txbyte <= rd_data;
               bitcnt <= '0;
               state  <= ST_HOLD;
            end
            ST_HOLD: if (hold_done) state <= is_rd ? ST_RDATA : ST_WDATA;
            ST_WDATA: if (scl_r) begin
               shreg  <= in_byte[DW-2:0];
               bitcnt <= bitcnt + BIT_W'(1);
               if (bitcnt == BIT_W'(DW-1)) state <= ST_WACK_WAIT;
            end
            ST_WACK_WAIT: if (scl_f) begin
               sda_oe <= 1'b1;
               state  <= ST_WACK;
            end
            ST_WACK: if (scl_f) begin
               sda_oe <= 1'b0;
               state  <= ST_SKIP;
            end
            ST_RDATA: begin
               if (scl_r) bitcnt <= bitcnt + BIT_W'(1);
               if (scl_f) begin
                  if (bitcnt == BIT_W'(DW)) begin
                     sda_oe <= 1'b0;
                     state  <= ST_RACK;
                  end else begin
                     sda_oe <= ~txbyte[3'(3'd7 - bitcnt[2:0])];
                  end
               end
            end
            ST_RACK: if (scl_r) state <= ST_SKIP;
            default: ;
         endcase
      end
   end

   // Checker state: length of the current SCL hold run.
   logic [STRETCH_W:0] hold_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hold_run <= '0;
      else if (scl_oe) hold_run <= hold_run + 1'b1;
      else             hold_run <= '0;
   end

   assert_sda_moves_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_s));
   assert_silent_after_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_SKIP) |-> !sda_oe);
   assert_hold_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hold_run <= {1'b0, stretch_cycles});
   assert_no_hold_when_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stretch_cycles == '0 && $past(stretch_cycles) == '0) |-> !scl_oe);
   assert_release_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stop_ev) |-> (!sda_oe && state == ST_IDLE));
endmodule

// File: tb/tb_i2c_quad_target.sv
`timescale 1ns/1ps
module tb_i2c_quad_target;
   localparam int Q = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       scl_c = 1'b1, sda_c = 1'b1;
   logic [7:0] stretch = 8'd0;
   logic       scl_oe, sda_oe;
   logic [31:0] tgt_data;
   logic [3:0]  wr_strobe;
   wire scl_bus = scl_c & ~scl_oe;
   wire sda_bus = sda_c & ~sda_oe;

   i2c_quad_target dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .stretch_cycles(stretch), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .tgt_data(tgt_data), .wr_strobe(wr_strobe));

   int errors = 0, checks = 0;
   bit done = 0;

   // Reference model of the four registers and one pending write.
   logic [7:0] mreg [4];
   bit         pend = 0;
   int         pend_idx = 0;
   logic [7:0] pend_val = '0;

   int   mon_bad = 0, sda_bad = 0, hold_cnt = 0, strobe_cyc = 0;
   logic [3:0] strobe_or = '0;
   logic prev_oe = 1'b0, prev_scl = 1'b1;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_flat();
      return {mreg[3], mreg[2], mreg[1], mreg[0]};
   endfunction

   // Per-clock comparison against the model and bus-rule monitor.
   always @(negedge clk) begin
      if (rst_n) begin
         logic [31:0] alt;
         alt = model_flat();
         if (pend) alt[pend_idx*8 +: 8] = pend_val;
         if (tgt_data !== model_flat() && !(pend && tgt_data === alt)) mon_bad++;
         if (sda_oe !== prev_oe && scl_bus && prev_scl) sda_bad++;
         if (scl_oe) hold_cnt++;
         if (wr_strobe != 0) begin
            strobe_cyc++;
            strobe_or = strobe_or | wr_strobe;
         end
      end
      prev_oe  = sda_oe;
      prev_scl = scl_bus;
   end

   task automatic wt(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clk_bit(input logic b, output logic got);
      wt(Q);
      sda_c = b;
      wt(Q);
      scl_c = 1'b1;
      while (scl_bus !== 1'b1) wt(1);
      wt(Q);
      @(negedge clk);
      got = sda_bus;
      wt(Q);
      scl_c = 1'b0;
   endtask

   task automatic do_start();
      sda_c = 1'b1;
      wt(Q);
      scl_c = 1'b1;
      while (scl_bus !== 1'b1) wt(1);
      wt(Q);
      sda_c = 1'b0;
      wt(Q);
      scl_c = 1'b0;
   endtask

   task automatic do_stop();
      wt(Q);
      sda_c = 1'b0;
      wt(Q);
      scl_c = 1'b1;
      while (scl_bus !== 1'b1) wt(1);
      wt(Q);
      sda_c = 1'b1;
      wt(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output bit acked);
      logic d;
      for (int i = 7; i >= 0; i--) clk_bit(v[i], d);
      clk_bit(1'b1, d);
      acked = (d == 1'b0);
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] v);
      logic d;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, d);
         v[i] = d;
      end
      clk_bit(give_ack ? 1'b0 : 1'b1, d);
   endtask

   task automatic wr_txn(input logic [6:0] a, input logic [7:0] v, input bit expect_ack, input string tag);
      bit ak, dk;
      strobe_or = '0; strobe_cyc = 0;
      do_start();
      send_byte({a, 1'b0}, ak);
      chk(ak == expect_ack, {tag, " address ack"}, ak, expect_ack);
      if (expect_ack) begin
         pend = 1; pend_idx = a[1:0]; pend_val = v;
      end
      send_byte(v, dk);
      chk(dk == expect_ack, {tag, " data ack"}, dk, expect_ack);
      do_stop();
      if (expect_ack) begin
         mreg[pend_idx] = v;
         pend = 0;
         chk(strobe_or == (4'b1 << a[1:0]) && strobe_cyc == 1, {tag, " R4 strobe"},
             {strobe_cyc[27:0], strobe_or}, {28'd1, 4'b1 << a[1:0]});
      end else begin
         chk(strobe_cyc == 0, {tag, " R3 no strobe"}, strobe_cyc, 0);
      end
      chk(tgt_data === model_flat(), {tag, " R6 registers"}, tgt_data, model_flat());
   endtask

   task automatic rd_txn(input logic [6:0] a, input bit give_ack, input string tag, output logic [7:0] v);
      bit ak;
      do_start();
      send_byte({a, 1'b1}, ak);
      chk(ak, {tag, " R2 address ack"}, ak, 1);
      recv_byte(give_ack, v);
   endtask

   initial begin
      logic [7:0] rv;
      bit ak;
      logic d;
      bit quiet;
      for (int i = 0; i < 4; i++) mreg[i] = {6'b110011, 2'(i)};
      wt(5);
      chk(sda_oe === 1'b0 && scl_oe === 1'b0, "R1 reset line enables", {sda_oe, scl_oe}, 0);
      chk(wr_strobe === 4'b0, "R1 reset strobe", wr_strobe, 0);
      chk(tgt_data === 32'hCFCECDCC, "R1 reset registers", tgt_data, 32'hCFCECDCC);
      rst_n = 1'b1;
      wt(5);

      // R2 R5 R7: plain read of target 0, no stretch.
      hold_cnt = 0;
      rd_txn(7'h54, 1'b0, "t0 read", rv);
      do_stop();
      chk(rv == 8'hCC, "R5 read target 0", rv, 8'hCC);
      chk(hold_cnt == 0, "R7 zero stretch", hold_cnt, 0);

      // R9: read target 3 with controller acknowledge, then clock more bits.
      rd_txn(7'h57, 1'b1, "t3 read", rv);
      chk(rv == 8'hCF, "R5 read target 3", rv, 8'hCF);
      quiet = 1;
      for (int i = 0; i < 9; i++) begin
         clk_bit(1'b1, d);
         if (d !== 1'b1) quiet = 0;
      end
      chk(quiet, "R9 silent after read byte", quiet, 1);
      do_stop();

      // R4 R6: write target 2, read it back, others kept.
      wr_txn(7'h56, 8'hA5, 1, "t2 write");
      rd_txn(7'h56, 1'b0, "t2 readback", rv);
      do_stop();
      chk(rv == 8'hA5, "R6 read after write", rv, 8'hA5);

      // R3: mismatching addresses.
      wr_txn(7'h34, 8'hFF, 0, "mismatch 34");
      wr_txn(7'h74, 8'h00, 0, "mismatch 74");

      // R7: stretched transactions.
      stretch = 8'd20; hold_cnt = 0;
      rd_txn(7'h55, 1'b0, "t1 stretched read", rv);
      do_stop();
      chk(rv == 8'hCD, "R7 read under stretch", rv, 8'hCD);
      chk(hold_cnt == 20, "R7 stretch length 20", hold_cnt, 20);
      stretch = 8'd5; hold_cnt = 0;
      wr_txn(7'h55, 8'h5A, 1, "t1 stretched write");
      chk(hold_cnt == 5, "R7 stretch length 5", hold_cnt, 5);
      stretch = 8'd0;

      // R8: repeated START in the middle of a write byte.
      do_start();
      send_byte({7'h54, 1'b0}, ak);
      chk(ak, "R8 address before abort", ak, 1);
      for (int i = 0; i < 4; i++) clk_bit(1'b0, d);
      do_start();
      send_byte({7'h57, 1'b1}, ak);
      chk(ak, "R8 address after repeated start", ak, 1);
      recv_byte(1'b0, rv);
      do_stop();
      chk(rv == 8'hCF, "R8 read after repeated start", rv, 8'hCF);
      chk(tgt_data === model_flat(), "R8 aborted byte not stored", tgt_data, model_flat());

      // R8: STOP in the middle of a write byte.
      do_start();
      send_byte({7'h55, 1'b0}, ak);
      for (int i = 0; i < 3; i++) clk_bit(1'b1, d);
      do_stop();
      chk(tgt_data === model_flat(), "R8 stop aborts write", tgt_data, model_flat());

      // R6: write target 0, other targets stay.
      wr_txn(7'h54, 8'h3C, 1, "t0 write");
      rd_txn(7'h54, 1'b0, "t0 readback", rv);
      do_stop();
      chk(rv == 8'h3C, "R6 target 0 new value", rv, 8'h3C);

      chk(mon_bad == 0, "R6 per-clock register model", mon_bad, 0);
      chk(sda_bad == 0, "R5 SDA moved with SCL high", sda_bad, 0);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule